// File: doc/BRIEF.md
# Two-Port Block Memory with Per-Port Word Shape

This block is an 18-kilobit synchronous memory with two fully independent ports, each on its own clock. The storage is 16 Kbit of data plus 2 Kbit of parity. Each port sees the same storage through its own word shape, so one side can write narrow words while the other reads wide words, or the reverse. The shape of each port is fixed by a parameter: 1, 2 or 4 bits with no parity, 8 data bits with one parity bit, or 16 data bits with two parity bits.

Every port operation happens on a rising edge of that port's clock while its enable is high. A port can read, write (the output then shows the new word), or load its output register with a constant while leaving the memory as it is. The start-up contents of data and parity are set by two wide parameters. If both ports write the same bit in the same cycle, the result is undefined and callers must avoid it.

Top module: `tdp_ram_aspect`

## Requirements
- R1: The port shape parameter WIDTH accepts 1, 2, 4, 9 and 18. These give 16384×1, 8192×2 and 4096×4 with no parity, 2048×(8+1) and 1024×(16+2), with 14, 13, 12, 11 and 10 address bits respectively. The parity pins are one bit wide in the 1, 2, 4 and 9 shapes and two bits wide in the 18 shape. Any other value stops elaboration.
- R2: With enable high and write and output reset low, the word and parity at the address appear on the port's outputs after that port's next rising clock edge.
- R3: With enable and write high, the data and parity inputs are stored at the address on the rising edge. No other bit of the storage changes.
- R4: On a write without output reset, the outputs show the data and parity just written after the same edge.
- R5: While enable is low, a port neither reads nor writes, and its outputs keep their values.
- R6: With enable and output reset high, the outputs take the port's reset constants after the edge (data RST_DATA, low bits; parity RST_PAR, bit 0 in the 9-bit shape). The memory is not changed by the reset.
- R7: For a port of D data bits, address a selects data bits a·D to a·D+D−1 of the 16 Kbit array. The sub-word index is therefore the low part of the address, and sub-word n lies at bits n·D of the wider word. In the 9-bit shape, address a carries parity bit a of the 2 Kbit parity array. For the 18-bit shape at address w/2, this is parity bit (w mod 2).
- R8: Data and parity written through one port read back through the other port with that port's own shape, even when the two shapes differ.
- R9: At start-up, data bit k equals INIT_DATA bit k and parity bit k equals INIT_PAR bit k, under the mapping of R7.
- R10: In the 1, 2 and 4-bit shapes, the parity input is ignored and the parity output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pa_clk | input | 1 | Port A clock |
| pa_en | input | 1 | Port A enable |
| pa_we | input | 1 | Port A write |
| pa_srst | input | 1 | Port A output register reset (synchronous) |
| pa_addr | input | 14/13/12/11/10 by WIDTH_A | Port A address |
| pa_wdata | input | 1/2/4/8/16 by WIDTH_A | Port A write data |
| pa_wpar | input | 1, or 2 when WIDTH_A=18 | Port A write parity |
| pa_rdata | output | 1/2/4/8/16 by WIDTH_A | Port A read data |
| pa_rpar | output | 1, or 2 when WIDTH_A=18 | Port A read parity |
| pb_clk | input | 1 | Port B clock |
| pb_en | input | 1 | Port B enable |
| pb_we | input | 1 | Port B write |
| pb_srst | input | 1 | Port B output register reset (synchronous) |
| pb_addr | input | 14/13/12/11/10 by WIDTH_B | Port B address |
| pb_wdata | input | 1/2/4/8/16 by WIDTH_B | Port B write data |
| pb_wpar | input | 1, or 2 when WIDTH_B=18 | Port B write parity |
| pb_rdata | output | 1/2/4/8/16 by WIDTH_B | Port B read data |
| pb_rpar | output | 1, or 2 when WIDTH_B=18 | Port B read parity |

## Verification
Each port result (read word, written word or reset constant) is due one rising edge of that port's own clock after the request, because the only register between a request and the output is the output register. The bench applies each request at a falling edge and waits through one rising edge. It samples at the following falling edge, then drops enable there. A value written through one port is read by the other port only after the write's edge has passed, so results never depend on how the two clocks line up.

// File: rtl/tdpra_pkg.sv
package tdpra_pkg;

   localparam int WORDS  = 1024;
   localparam int IDXW   = $clog2(WORDS);
   localparam int DBITS  = 16;
   localparam int PBITS  = 2;
   localparam int WBITS  = DBITS + PBITS;
   localparam int DTOTAL = WORDS * DBITS;
   localparam int PTOTAL = WORDS * PBITS;
   localparam int ITOTAL = WORDS * WBITS;

   function automatic bit width_ok(input int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18);
   endfunction

   function automatic int data_bits(input int w);
      case (w)
         1:       return 1;
         2:       return 2;
         4:       return 4;
         9:       return 8;
         18:      return 16;
         default: return 1;
      endcase
   endfunction

   function automatic int par_bits(input int w);
      return (w == 9) ? 1 : ((w == 18) ? 2 : 0);
   endfunction

   function automatic int par_pins(input int w);
      return (par_bits(w) == 0) ? 1 : par_bits(w);
   endfunction

   function automatic int lane_bits(input int w);
      return $clog2(DBITS / data_bits(w));
   endfunction

   function automatic int addr_bits(input int w);
      return IDXW + lane_bits(w);
   endfunction

   function automatic logic [ITOTAL-1:0] pack_init(input logic [DTOTAL-1:0] d,
                                                   input logic [PTOTAL-1:0] p);
      logic [ITOTAL-1:0] r;
      r = '0;
      for (int i = 0; i < WORDS; i++)
         r[i*WBITS +: WBITS] = {p[i*PBITS +: PBITS], d[i*DBITS +: DBITS]};
      return r;
   endfunction

endpackage

// File: rtl/tdpra_bank.sv
module tdpra_bank
   import tdpra_pkg::*;
#(
   parameter logic [ITOTAL-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic [IDXW-1:0]  widx,
   input  logic [WBITS-1:0] wmask,
   input  logic [WBITS-1:0] wd,
   input  logic [IDXW-1:0]  ridx0,
   output logic [WBITS-1:0] rq0,
   input  logic [IDXW-1:0]  ridx1,
   output logic [WBITS-1:0] rq1
);

   logic [WBITS-1:0] mem [WORDS];

   initial begin
      for (int i = 0; i < WORDS; i++)
         mem[i] = INIT[i*WBITS +: WBITS];
   end

   always_ff @(posedge clk) begin
      if (|wmask)
         mem[widx] <= (mem[widx] & ~wmask) | (wd & wmask);
   end

   assign rq0 = mem[ridx0];
   assign rq1 = mem[ridx1];

   logic             started = 1'b0;
   logic [IDXW-1:0]  widx_q;
   logic [WBITS-1:0] wd_q;
   logic [WBITS-1:0] wm_q;

   always_ff @(posedge clk) begin
      started <= 1'b1;
      widx_q  <= widx;
      wd_q    <= wd;
      wm_q    <= wmask;
   end

   // R3
   bank_store_chk: assert property (@(posedge clk) disable iff (!started)
      (|wm_q) |-> (((mem[widx_q] ^ wd_q) & wm_q) == '0));

endmodule

// File: rtl/tdpra_port.sv
module tdpra_port
   import tdpra_pkg::*;
#(
   parameter int          WIDTH    = 18,
   parameter logic [15:0] RST_DATA = '0,
   parameter logic [1:0]  RST_PAR  = '0,
   localparam int DW  = data_bits(WIDTH),
   localparam int PW  = par_bits(WIDTH),
   localparam int PPW = par_pins(WIDTH),
   localparam int LB  = lane_bits(WIDTH),
   localparam int AW  = addr_bits(WIDTH)
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic             srst,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic [PPW-1:0]   wpar,
   output logic [DW-1:0]    rdata,
   output logic [PPW-1:0]   rpar,
   output logic [IDXW-1:0]  idx,
   output logic [WBITS-1:0] wmask,
   output logic [WBITS-1:0] wword,
   input  logic [WBITS-1:0] word_in
);

   localparam logic [DBITS-1:0] DMASK = DBITS'((32'd1 << DW) - 32'd1);

   if (!width_ok(WIDTH)) begin : g_bad_width
      $error("tdpra_port: WIDTH %0d is not one of 1, 2, 4, 9, 18", WIDTH);
   end

   logic [3:0] lane_sel;
   logic [4:0] dshift;

   if (LB == 0) begin : g_wide
      assign idx      = addr;
      assign lane_sel = 4'd0;
   end else begin : g_narrow
      assign idx      = addr[AW-1:LB];
      assign lane_sel = 4'(addr[LB-1:0]);
   end

   assign dshift = 5'(lane_sel) * 5'(DW);

   logic [PBITS-1:0] pmask;
   logic [PBITS-1:0] pword;
   logic [PPW-1:0]   rp_next;
   logic [PPW-1:0]   rp_wr;
   logic [PPW-1:0]   rp_rst;

   if (PW == 0) begin : g_nopar
      assign pmask   = '0;
      assign pword   = '0;
      assign rp_next = '0;
      assign rp_wr   = '0;
      assign rp_rst  = '0;
      logic unused_par;
      assign unused_par = ^{word_in[WBITS-1:DBITS], wpar};
   end else if (PW == 1) begin : g_par1
      assign pmask   = lane_sel[0] ? 2'b10 : 2'b01;
      assign pword   = {2{wpar[0]}};
      assign rp_next = lane_sel[0] ? word_in[DBITS+1] : word_in[DBITS];
      assign rp_wr   = wpar;
      assign rp_rst  = RST_PAR[0];
   end else begin : g_par2
      assign pmask   = 2'b11;
      assign pword   = wpar;
      assign rp_next = word_in[WBITS-1:DBITS];
      assign rp_wr   = wpar;
      assign rp_rst  = RST_PAR;
   end

   logic [DW-1:0] rd_next;
   assign rd_next = DW'(word_in[DBITS-1:0] >> dshift);

   always_comb begin
      wmask = '0;
      wword = '0;
      if (en && we) begin
         wmask = {pmask, DMASK << dshift};
         wword = {pword, DBITS'(wdata) << dshift};
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (srst) begin
            rdata <= RST_DATA[DW-1:0];
            rpar  <= rp_rst;
         end else if (we) begin
            rdata <= wdata;
            rpar  <= rp_wr;
         end else begin
            rdata <= rd_next;
            rpar  <= rp_next;
         end
      end
   end

   logic started = 1'b0;
   always_ff @(posedge clk) started <= 1'b1;

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!started)
      !en |=> ($stable(rdata) && $stable(rpar)));

   // R4
   wr_first_chk: assert property (@(posedge clk) disable iff (!started)
      (en && we && !srst) |=> (rdata == $past(wdata)));

   // R6
   srst_value_chk: assert property (@(posedge clk) disable iff (!started)
      (en && srst) |=> (rdata == RST_DATA[DW-1:0]));

endmodule

// File: rtl/tdp_ram_aspect.sv
module tdp_ram_aspect
   import tdpra_pkg::*;
#(
   parameter int                WIDTH_A    = 9,
   parameter int                WIDTH_B    = 18,
   parameter logic [15:0]       RST_DATA_A = '0,
   parameter logic [1:0]        RST_PAR_A  = '0,
   parameter logic [15:0]       RST_DATA_B = '0,
   parameter logic [1:0]        RST_PAR_B  = '0,
   parameter logic [DTOTAL-1:0] INIT_DATA  = '0,
   parameter logic [PTOTAL-1:0] INIT_PAR   = '0
) (
   input  logic                             pa_clk,
   input  logic                             pa_en,
   input  logic                             pa_we,
   input  logic                             pa_srst,
   input  logic [addr_bits(WIDTH_A)-1:0]    pa_addr,
   input  logic [data_bits(WIDTH_A)-1:0]    pa_wdata,
   input  logic [par_pins(WIDTH_A)-1:0]     pa_wpar,
   output logic [data_bits(WIDTH_A)-1:0]    pa_rdata,
   output logic [par_pins(WIDTH_A)-1:0]     pa_rpar,
   input  logic                             pb_clk,
   input  logic                             pb_en,
   input  logic                             pb_we,
   input  logic                             pb_srst,
   input  logic [addr_bits(WIDTH_B)-1:0]    pb_addr,
   input  logic [data_bits(WIDTH_B)-1:0]    pb_wdata,
   input  logic [par_pins(WIDTH_B)-1:0]     pb_wpar,
   output logic [data_bits(WIDTH_B)-1:0]    pb_rdata,
   output logic [par_pins(WIDTH_B)-1:0]     pb_rpar
);

   localparam logic [ITOTAL-1:0] INIT_FULL = pack_init(INIT_DATA, INIT_PAR);

   logic [IDXW-1:0]  idx   [2];
   logic [WBITS-1:0] wmask [2];
   logic [WBITS-1:0] wword [2];
   logic [WBITS-1:0] wd    [2];
   logic [WBITS-1:0] q_at_a [2];
   logic [WBITS-1:0] q_at_b [2];
   logic [WBITS-1:0] word_a;
   logic [WBITS-1:0] word_b;
   logic             bclk  [2];

   assign bclk[0] = pa_clk;
   assign bclk[1] = pb_clk;

   // logical contents are the XOR of the two banks
   assign word_a = q_at_a[0] ^ q_at_a[1];
   assign word_b = q_at_b[0] ^ q_at_b[1];
   assign wd[0]  = wword[0] ^ q_at_a[1];
   assign wd[1]  = wword[1] ^ q_at_b[0];

   tdpra_port #(
      .WIDTH    (WIDTH_A),
      .RST_DATA (RST_DATA_A),
      .RST_PAR  (RST_PAR_A)
   ) u_port_a (
      .clk     (pa_clk),
      .en      (pa_en),
      .we      (pa_we),
      .srst    (pa_srst),
      .addr    (pa_addr),
      .wdata   (pa_wdata),
      .wpar    (pa_wpar),
      .rdata   (pa_rdata),
      .rpar    (pa_rpar),
      .idx     (idx[0]),
      .wmask   (wmask[0]),
      .wword   (wword[0]),
      .word_in (word_a)
   );

   tdpra_port #(
      .WIDTH    (WIDTH_B),
      .RST_DATA (RST_DATA_B),
      .RST_PAR  (RST_PAR_B)
   ) u_port_b (
      .clk     (pb_clk),
      .en      (pb_en),
      .we      (pb_we),
      .srst    (pb_srst),
      .addr    (pb_addr),
      .wdata   (pb_wdata),
      .wpar    (pb_wpar),
      .rdata   (pb_rdata),
      .rpar    (pb_rpar),
      .idx     (idx[1]),
      .wmask   (wmask[1]),
      .wword   (wword[1]),
      .word_in (word_b)
   );

   for (genvar g = 0; g < 2; g++) begin : g_bank
      tdpra_bank #(
         .INIT ((g == 0) ? INIT_FULL : '0)
      ) u_bank (
         .clk   (bclk[g]),
         .widx  (idx[g]),
         .wmask (wmask[g]),
         .wd    (wd[g]),
         .ridx0 (idx[0]),
         .rq0   (q_at_a[g]),
         .ridx1 (idx[1]),
         .rq1   (q_at_b[g])
      );
   end

endmodule

// File: tb/tdp_ram_aspect_test.sv
module tdp_ram_aspect_test;

   localparam int CLK_PERIOD   = 10;
   localparam int CLK_PERIOD_B = 14;

   function automatic logic [15:0] iw(input int i);
      return 16'(i * 40503 + 7);
   endfunction

   function automatic logic [1:0] ip(input int i);
      return 2'(i ^ (i >> 3));
   endfunction

   function automatic logic [16383:0] mk_data();
      logic [16383:0] r;
      for (int i = 0; i < 1024; i++) r[i*16 +: 16] = iw(i);
      return r;
   endfunction

   function automatic logic [2047:0] mk_par();
      logic [2047:0] r;
      for (int i = 0; i < 1024; i++) r[i*2 +: 2] = ip(i);
      return r;
   endfunction

   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   always #(CLK_PERIOD / 2) clk_a = ~clk_a;
   always #(CLK_PERIOD_B / 2) clk_b = ~clk_b;

   // main instance: port A 2K x 9, port B 1K x 18
   logic        a_en = 0, a_we = 0, a_rst = 0;
   logic [10:0] a_addr = '0;
   logic [7:0]  a_din = '0;
   logic [0:0]  a_dp = '0;
   logic [7:0]  a_do;
   logic [0:0]  a_dop;
   logic        b_en = 0, b_we = 0, b_rst = 0;
   logic [9:0]  b_addr = '0;
   logic [15:0] b_din = '0;
   logic [1:0]  b_dp = '0;
   logic [15:0] b_do;
   logic [1:0]  b_dop;

   tdp_ram_aspect #(
      .WIDTH_A    (9),
      .WIDTH_B    (18),
      .RST_DATA_A (16'hC35A),
      .RST_PAR_A  (2'b10),
      .RST_DATA_B (16'h0F96),
      .RST_PAR_B  (2'b01),
      .INIT_DATA  (mk_data()),
      .INIT_PAR   (mk_par())
   ) uut (
      .pa_clk (clk_a), .pa_en (a_en), .pa_we (a_we), .pa_srst (a_rst),
      .pa_addr (a_addr), .pa_wdata (a_din), .pa_wpar (a_dp),
      .pa_rdata (a_do), .pa_rpar (a_dop),
      .pb_clk (clk_b), .pb_en (b_en), .pb_we (b_we), .pb_srst (b_rst),
      .pb_addr (b_addr), .pb_wdata (b_din), .pb_wpar (b_dp),
      .pb_rdata (b_do), .pb_rpar (b_dop)
   );

   // narrow instance: port A 16K x 1, port B 4K x 4
   logic        na_en = 0, na_we = 0;
   logic [13:0] na_addr = '0;
   logic [0:0]  na_din = '0;
   logic [0:0]  na_dp = '0;
   logic [0:0]  na_do;
   logic [0:0]  na_dop;
   logic        nb_en = 0, nb_we = 0;
   logic [11:0] nb_addr = '0;
   logic [3:0]  nb_din = '0;
   logic [0:0]  nb_dp = '0;
   logic [3:0]  nb_do;
   logic [0:0]  nb_dop;

   tdp_ram_aspect #(
      .WIDTH_A (1),
      .WIDTH_B (4)
   ) uut_n (
      .pa_clk (clk_a), .pa_en (na_en), .pa_we (na_we), .pa_srst (1'b0),
      .pa_addr (na_addr), .pa_wdata (na_din), .pa_wpar (na_dp),
      .pa_rdata (na_do), .pa_rpar (na_dop),
      .pb_clk (clk_b), .pb_en (nb_en), .pb_we (nb_we), .pb_srst (1'b0),
      .pb_addr (nb_addr), .pb_wdata (nb_din), .pb_wpar (nb_dp),
      .pb_rdata (nb_do), .pb_rpar (nb_dop)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic op_a(input logic en, we, rst, input logic [10:0] ad,
                       input logic [7:0] d, input logic p);
      @(negedge clk_a);
      a_en = en; a_we = we; a_rst = rst; a_addr = ad; a_din = d; a_dp = p;
      @(posedge clk_a);
      @(negedge clk_a);
      a_en = 0; a_we = 0; a_rst = 0;
   endtask

   task automatic op_b(input logic en, we, rst, input logic [9:0] ad,
                       input logic [15:0] d, input logic [1:0] p);
      @(negedge clk_b);
      b_en = en; b_we = we; b_rst = rst; b_addr = ad; b_din = d; b_dp = p;
      @(posedge clk_b);
      @(negedge clk_b);
      b_en = 0; b_we = 0; b_rst = 0;
   endtask

   task automatic op_na(input logic we, input logic [13:0] ad, input logic d, input logic p);
      @(negedge clk_a);
      na_en = 1; na_we = we; na_addr = ad; na_din = d; na_dp = p;
      @(posedge clk_a);
      @(negedge clk_a);
      na_en = 0; na_we = 0;
   endtask

   task automatic op_nb(input logic we, input logic [11:0] ad, input logic [3:0] d, input logic p);
      @(negedge clk_b);
      nb_en = 1; nb_we = we; nb_addr = ad; nb_din = d; nb_dp = p;
      @(posedge clk_b);
      @(negedge clk_b);
      nb_en = 0; nb_we = 0;
   endtask

   task automatic test_shapes();
      chk("R1 addr A 9-bit",  $bits(a_addr),  11);
      chk("R1 addr B 18-bit", $bits(b_addr),  10);
      chk("R1 data B width",  $bits(b_do),    16);
      chk("R1 par B width",   $bits(b_dop),   2);
      chk("R1 addr 1-bit",    $bits(na_addr), 14);
      chk("R1 addr 4-bit",    $bits(nb_addr), 12);
   endtask

   task automatic test_reset();
      op_a(1, 0, 1, 11'd11, 8'h00, 1'b0);
      chk("R6 A reset data", a_do, 8'h5A);
      chk("R6 A reset par",  a_dop, 1'b0);
      op_b(1, 0, 1, 10'd5, 16'h0, 2'b0);
      chk("R6 B reset data", b_do, 16'h0F96);
      chk("R6 B reset par",  b_dop, 2'b01);
      op_a(1, 0, 0, 11'd11, 8'h00, 1'b0);
      chk("R6 memory kept after reset", a_do, iw(5)[15:8]);
   endtask

   task automatic test_init();
      logic [1:0] p;
      op_b(1, 0, 0, 10'd5, 16'h0, 2'b0);
      chk("R9 R2 B init data", b_do, iw(5));
      chk("R9 R2 B init par",  b_dop, ip(5));
      op_a(1, 0, 0, 11'd11, 8'h00, 1'b0);
      p = ip(5);
      chk("R7 R9 A upper lane data", a_do, iw(5)[15:8]);
      chk("R7 R9 A upper lane par",  a_dop, p[1]);
      op_a(1, 0, 0, 11'd10, 8'h00, 1'b0);
      chk("R7 R9 A lower lane data", a_do, iw(5)[7:0]);
      chk("R7 R9 A lower lane par",  a_dop, p[0]);
   endtask

   task automatic test_write_a();
      op_a(1, 1, 0, 11'd20, 8'hA5, 1'b1);
      chk("R4 A write-first data", a_do, 8'hA5);
      chk("R4 A write-first par",  a_dop, 1'b1);
      op_a(1, 1, 0, 11'd21, 8'h3C, 1'b0);
      op_b(1, 0, 0, 10'd10, 16'h0, 2'b0);
      chk("R8 R3 B reads A writes", b_do, 16'h3CA5);
      chk("R8 R7 B reads A parity", b_dop, 2'b01);
      op_b(1, 0, 0, 10'd11, 16'h0, 2'b0);
      chk("R3 neighbour untouched", b_do, iw(11));
      op_a(1, 0, 0, 11'd20, 8'h00, 1'b0);
      chk("R2 R3 A reads own write", a_do, 8'hA5);
   endtask

   task automatic test_idle();
      op_a(0, 1, 0, 11'd20, 8'hFF, 1'b0);
      chk("R5 idle holds data", a_do, 8'hA5);
      chk("R5 idle holds par",  a_dop, 1'b1);
      op_b(1, 0, 0, 10'd10, 16'h0, 2'b0);
      chk("R5 idle did not write", b_do, 16'h3CA5);
   endtask

   task automatic test_write_b();
      op_b(1, 1, 0, 10'd30, 16'hBEEF, 2'b10);
      chk("R4 B write-first data", b_do, 16'hBEEF);
      chk("R4 B write-first par",  b_dop, 2'b10);
      op_a(1, 0, 0, 11'd60, 8'h00, 1'b0);
      chk("R8 A low byte",   a_do, 8'hEF);
      chk("R8 A low parity", a_dop, 1'b0);
      op_a(1, 0, 0, 11'd61, 8'h00, 1'b0);
      chk("R8 A high byte",   a_do, 8'hBE);
      chk("R8 A high parity", a_dop, 1'b1);
   endtask

   task automatic test_narrow();
      op_na(1, 14'd28, 1'b1, 1'b1);
      chk("R10 1-bit parity out zero", na_dop, 1'b0);
      op_na(1, 14'd29, 1'b0, 1'b1);
      op_na(1, 14'd30, 1'b1, 1'b1);
      op_na(1, 14'd31, 1'b1, 1'b1);
      op_nb(0, 12'd7, 4'h0, 1'b0);
      chk("R7 R8 4-bit gathers bits", nb_do, 4'b1101);
      chk("R10 4-bit parity out zero", nb_dop, 1'b0);
      op_nb(1, 12'd9, 4'h6, 1'b1);
      chk("R10 4-bit write parity zero", nb_dop, 1'b0);
      for (int k = 0; k < 4; k++) begin
         logic [3:0] e;
         e = 4'h6;
         op_na(0, 14'(36 + k), 1'b0, 1'b0);
         chk("R7 R8 1-bit reads nibble", na_do, e[k]);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk_a);
      test_shapes();
      test_reset();
      test_init();
      test_write_a();
      test_idle();
      test_write_b();
      test_narrow();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule